// File: doc/BRIEF.md
# Predicated Vector Duplicate Unit

This block executes a vector-duplicate instruction. It decodes a 32-bit instruction word, replicates a 32-bit scalar operand across a 128-bit destination vector at 8-, 16- or 32-bit lane granularity, and merges the replicated value into the current destination contents under a 16-bit per-byte predicate. Bytes whose predicate bit is clear keep their old contents. A wide lane can therefore be updated only in part.

Operands enter through a valid/ready input channel. The result leaves through a valid/ready output channel that is backed by a single output register. The input is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `res_valid` is high and `res_ready` is low, the result holds still and no new input is taken. The result carries the merged vector, the destination register index, a write flag and an undefined-instruction flag. The register file and the predicate generator sit outside the block.

Top module: `vdup_unit`

## Requirements
- R1: An instruction is recognised only when bits 31:23 = 1_1101_1101, bits 21:20 = 10, bit 16 = 0, bits 11:8 = 1011, bit 6 = 0, bit 4 = 1 and bits 3:0 = 0000. Any other word raises `res_undef`.
- R2: Lane size comes from bit 22 (B) and bit 5 (E): B=1,E=0 gives 8-bit lanes; B=0,E=1 gives 16-bit lanes; B=0,E=0 gives 32-bit lanes. B=1,E=1 raises `res_undef`.
- R3: `res_qidx` = {bit 7, bits 19:17}. When bit 7 is set, `res_undef` is raised.
- R4: A source register number (bits 15:12) of 13 or 15 raises `res_undef`.
- R5: The replicated value is the low byte repeated 16 times, the low halfword repeated 8 times, or the whole word repeated 4 times, according to lane size.
- R6: Output byte i (bits 8i+7:8i) takes the replicated byte when `in_pmask[i]` is 1. Otherwise it keeps `in_old` byte i. This holds even inside a wider lane.
- R7: When `res_undef` is high, `res_vec` equals `in_old` and `res_wen` is low. Otherwise `res_wen` is high.
- R8: An input accepted at a rising edge appears with `res_valid` high after that same edge, which is one cycle of latency.
- R9: `in_ready` = !`res_valid` || `res_ready`. While `res_valid` is high and `res_ready` is low, the result outputs are held unchanged.
- R10: A synchronous active-low reset clears `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operands valid |
| in_ready | output | 1 | Block can take an input |
| in_ins | input | 32 | Instruction word |
| in_scalar | input | SCALAR_W | Scalar operand to replicate |
| in_old | input | VEC_W | Current destination vector contents |
| in_pmask | input | VEC_W/8 | Per-byte predicate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_vec | output | VEC_W | Merged destination vector |
| res_qidx | output | 4 | Destination register index |
| res_wen | output | 1 | Result should be written back |
| res_undef | output | 1 | Instruction undefined |

## Verification
The bound checker checks several rules on every cycle:
- the one-cycle handoff from an accepted input to a valid result;
- the stability of a stalled result;
- the exclusion between write and undefined flags;
- an all-zero predicate passing the old vector through;
- the undefined flag following a set index bit 7.

Only the bench scenarios can show the following:
- the exact replication pattern per lane size;
- partial predication inside halfword and word lanes;
- each single-field encoding violation;
- the merged vector values under random operands.

// File: rtl/vdup_pkg.sv
package vdup_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_H16 = 2'd1,
    LANE_W32 = 2'd2,
    LANE_BAD = 2'd3
  } lane_e;

  typedef struct packed {
    lane_e      lane;
    logic [3:0] qidx;
    logic       undef;
  } dec_t;
endpackage

// File: rtl/vdup_decode.sv
module vdup_decode
  import vdup_pkg::*;
(
  input  logic [31:0] ins,
  output dec_t        dec
);
  logic       fixed_ok;
  logic [3:0] src_reg;
  lane_e      lane;

  // R1 fixed opcode fields
  always_comb begin
    fixed_ok = (ins[31:23] == 9'b1_1101_1101) &&
               (ins[21:20] == 2'b10) &&
               (ins[16] == 1'b0) &&
               (ins[11:8] == 4'b1011) &&
               (ins[6] == 1'b0) &&
               (ins[4] == 1'b1) &&
               (ins[3:0] == 4'b0000);
  end

  // R2 size from split bits B (22) and E (5)
  always_comb begin
    unique case ({ins[22], ins[5]})
      2'b10:   lane = LANE_B8;
      2'b01:   lane = LANE_H16;
      2'b00:   lane = LANE_W32;
      default: lane = LANE_BAD;
    endcase
  end

  assign src_reg = ins[15:12];

  always_comb begin
    dec.lane  = lane;
    dec.qidx  = {ins[7], ins[19:17]};  // R3
    dec.undef = !fixed_ok || (lane == LANE_BAD) || ins[7] ||
                (src_reg == 4'd13) || (src_reg == 4'd15);  // R4
  end
endmodule

// File: rtl/vdup_replicate.sv
module vdup_replicate
  import vdup_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic [SCALAR_W-1:0] scalar,
  input  lane_e               lane,
  output logic [VEC_W-1:0]    rep
);
  localparam int NB = VEC_W / 8;
  localparam int SB = SCALAR_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] b8, h16, w32;
    assign b8  = scalar[7:0];
    assign h16 = scalar[8*(b % 2) +: 8];
    assign w32 = scalar[8*(b % SB) +: 8];
    always_comb begin
      unique case (lane)
        LANE_B8:  rep[8*b +: 8] = b8;
        LANE_H16: rep[8*b +: 8] = h16;
        default:  rep[8*b +: 8] = w32;
      endcase
    end
  end
endmodule

// File: rtl/vdup_merge.sv
module vdup_merge #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   old_vec,
  input  logic [VEC_W-1:0]   rep,
  input  logic [VEC_W/8-1:0] pmask,
  input  logic               kill,
  output logic [VEC_W-1:0]   merged
);
  localparam int NB = VEC_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic we;
    assign we = pmask[b] && !kill;  // R6 R7
    assign merged[8*b +: 8] = we ? rep[8*b +: 8] : old_vec[8*b +: 8];
  end
endmodule

// File: rtl/vdup_unit.sv
module vdup_unit
  import vdup_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_ins,
  input  logic [SCALAR_W-1:0]  in_scalar,
  input  logic [VEC_W-1:0]     in_old,
  input  logic [VEC_W/8-1:0]   in_pmask,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [VEC_W-1:0]     res_vec,
  output logic [3:0]           res_qidx,
  output logic                 res_wen,
  output logic                 res_undef
);
  dec_t             dec;
  logic [VEC_W-1:0] rep;
  logic [VEC_W-1:0] merged;
  logic             take;

  vdup_decode u_dec (.ins(in_ins), .dec(dec));

  vdup_replicate #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_rep (
    .scalar(in_scalar), .lane(dec.lane), .rep(rep));

  vdup_merge #(.VEC_W(VEC_W)) u_mrg (
    .old_vec(in_old), .rep(rep), .pmask(in_pmask),
    .kill(dec.undef), .merged(merged));

  assign in_ready = !res_valid || res_ready;  // R9
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;  // R10
    end else if (take) begin
      res_valid <= 1'b1;  // R8
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      res_vec   <= merged;
      res_qidx  <= dec.qidx;
      res_wen   <= !dec.undef;
      res_undef <= dec.undef;
    end
  end
endmodule

// File: rtl/vdup_unit_chk.sv
module vdup_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [31:0]        in_ins,
  input logic [VEC_W-1:0]   in_old,
  input logic [VEC_W/8-1:0] in_pmask,
  input logic               res_valid,
  input logic               res_ready,
  input logic [VEC_W-1:0]   res_vec,
  input logic               res_wen,
  input logic               res_undef
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_ACCEPT_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);  // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_vec)));  // R9
  AST_WEN_UNDEF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_wen != res_undef));  // R7
  AST_ZERO_MASK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_pmask == '0)) |=> (res_vec == $past(in_old)));  // R6
  AST_HIGH_INDEX_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_ins[7]) |=> res_undef);  // R3
endmodule

bind vdup_unit vdup_unit_chk #(.VEC_W(VEC_W)) chk_i (.*);

// File: tb/vdup_unit_tb_top.sv
`timescale 1ns/1ps
module vdup_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_ins = '0;
  logic [31:0]  in_scalar = '0;
  logic [127:0] in_old = '0;
  logic [15:0]  in_pmask = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [127:0] res_vec;
  logic [3:0]   res_qidx;
  logic         res_wen;
  logic         res_undef;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  vdup_unit dut_i (.*);

  function automatic logic [31:0] mk_ins(input logic b, input logic e,
                                         input logic [3:0] q, input logic [3:0] rt);
    mk_ins = 32'hEEA00B10 | (32'(b) << 22) | (32'(e) << 5) |
             (32'(q[3]) << 7) | (32'(q[2:0]) << 17) | (32'(rt) << 12);
  endfunction

  function automatic logic m_undef(input logic [31:0] w);
    logic ok;
    ok = (w[31:23] == 9'h1DD) && (w[21:20] == 2'b10) && !w[16] &&
         (w[11:8] == 4'hB) && !w[6] && w[4] && (w[3:0] == 4'h0);
    m_undef = !ok || (w[22] && w[5]) || w[7] ||
              (w[15:12] == 4'd13) || (w[15:12] == 4'd15);
  endfunction

  function automatic logic [127:0] m_vec(input logic [31:0] w, input logic [31:0] s,
                                         input logic [127:0] old, input logic [15:0] m);
    logic [127:0] rep;
    if (w[22]) rep = {16{s[7:0]}};
    else if (w[5]) rep = {8{s[15:0]}};
    else rep = {4{s}};
    m_vec = old;
    if (!m_undef(w))
      for (int i = 0; i < 16; i++) if (m[i]) m_vec[8*i +: 8] = rep[8*i +: 8];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] w, input logic [31:0] s,
                        input logic [127:0] old, input logic [15:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_ins = w; in_scalar = s; in_old = old; in_pmask = m;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R8 valid"}, 128'(res_valid), 128'(1));
    chk({req, " vec"}, res_vec, m_vec(w, s, old, m));
    chk({req, " R7 undef"}, 128'(res_undef), 128'(m_undef(w)));
    chk({req, " R7 wen"}, 128'(res_wen), 128'(!m_undef(w)));
    if (!m_undef(w)) chk({req, " R3 qidx"}, 128'(res_qidx), 128'({w[7], w[19:17]}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] ov;
    logic [31:0]  wa, wb;
    void'($urandom(32'hC0FFEE));
    ov = 128'h0F0E0D0C0B0A09080706050403020100;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 128'(res_valid), 128'(0));
    chk("R9 ready after reset", 128'(in_ready), 128'(1));
    rst_n = 1'b1;

    run_op("R5 byte", mk_ins(1, 0, 4'd2, 4'd1), 32'hA1B2C3D4, ov, 16'hFFFF);
    chk("R5 byte pattern", res_vec, {16{8'hD4}});
    run_op("R5 half", mk_ins(0, 1, 4'd5, 4'd3), 32'hA1B2C3D4, ov, 16'hFFFF);
    chk("R5 half pattern", res_vec, {8{16'hC3D4}});
    run_op("R5 word", mk_ins(0, 0, 4'd7, 4'd0), 32'hA1B2C3D4, ov, 16'hFFFF);
    chk("R5 word pattern", res_vec, {4{32'hA1B2C3D4}});
    run_op("R6 partial word", mk_ins(0, 0, 4'd1, 4'd2), 32'hA1B2C3D4, ov, 16'h0005);
    chk("R6 partial bytes", res_vec, {ov[127:24], 8'hB2, ov[15:8], 8'hD4});
    run_op("R6 zero mask", mk_ins(0, 1, 4'd0, 4'd4), 32'h12345678, ov, 16'h0000);
    chk("R6 old kept", res_vec, ov);
    run_op("R2 B1E1", mk_ins(1, 1, 4'd0, 4'd1), 32'h55, ov, 16'hFFFF);
    run_op("R3 index 8", mk_ins(0, 0, 4'd8, 4'd1), 32'h55, ov, 16'hFFFF);
    run_op("R4 rt13", mk_ins(0, 0, 4'd1, 4'd13), 32'h55, ov, 16'hFFFF);
    run_op("R4 rt15", mk_ins(0, 0, 4'd1, 4'd15), 32'h55, ov, 16'hFFFF);
    run_op("R4 rt14 ok", mk_ins(0, 0, 4'd1, 4'd14), 32'h55, ov, 16'hFFFF);
    run_op("R1 bit16", mk_ins(0, 0, 4'd1, 4'd1) | 32'h00010000, 32'h55, ov, 16'hFFFF);
    run_op("R1 bit6", mk_ins(0, 0, 4'd1, 4'd1) | 32'h00000040, 32'h55, ov, 16'hFFFF);
    run_op("R1 low nibble", mk_ins(0, 0, 4'd1, 4'd1) | 32'h00000001, 32'h55, ov, 16'hFFFF);

    // R9 back-pressure
    wa = mk_ins(1, 0, 4'd3, 4'd2);
    wb = mk_ins(0, 0, 4'd6, 4'd2);
    @(negedge clk);
    res_ready = 1'b0;
    in_valid = 1'b1; in_ins = wa; in_scalar = 32'h000000AA; in_old = ov; in_pmask = 16'hFFFF;
    @(negedge clk);
    in_ins = wb; in_scalar = 32'h11223344;
    chk("R9 ready low on stall", 128'(in_ready), 128'(0));
    @(negedge clk);
    chk("R9 held vec", res_vec, {16{8'hAA}});
    chk("R9 held valid", 128'(res_valid), 128'(1));
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next result", res_vec, {4{32'h11223344}});
    chk("R3 next qidx", 128'(res_qidx), 128'(6));
    @(negedge clk);
    chk("R9 drained", 128'(res_valid), 128'(0));

    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      logic [3:0]  q;
      q = ($urandom % 4 == 0) ? 4'($urandom) : {1'b0, 3'($urandom)};
      w = mk_ins(1'($urandom), 1'($urandom), q, 4'($urandom));
      if ($urandom % 10 == 0) w = $urandom;
      run_op("R6 random", w, $urandom,
             {$urandom, $urandom, $urandom, $urandom}, 16'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule